// File: doc/BRIEF.md
# Pixel Hit-Time Store with Trigger Match

This block keeps the recent hit history of one pixel as a short list of timestamps, so that no storage is spent on crossings without a hit. When the pixel fires, the current value of the free-running crossing counter is written into a free slot. When a level-1 trigger arrives, the block works out which crossing the trigger refers to: the present counter value less the fixed trigger latency, wrapped to the counter width. Any stored stamp equal to that crossing marks the pixel as selected for level-2 readout.

Stamps that fall out of the latency window are dropped on their own, so the store only holds hits a later trigger could still claim. A matched stamp is kept until the readout side acknowledges the read. The acknowledge clears the selection and frees the matched slots. A hit that finds every slot occupied is lost, and a sticky overflow flag records the loss. The defaults are an 8-bit counter, a latency of 120 crossings and 16 slots. The counter width may be at most 16 bits and the latency must be below the counter range.

Top module: `hit_time_store`

## Requirements
- R1: After reset, sel_o and ovf_o are 0 and every slot is free.
- R2: A hit_i stores time_i. An l1_i in a cycle where time_i equals that stamp plus 120 (mod 256) drives sel_o to 1 from the next cycle.
- R3: An l1_i in a cycle where no held stamp equals time_i minus 120 (mod 256) leaves sel_o at 0, including trigger offsets from 114 to 126 crossings other than 120.
- R4: The delayed-time arithmetic wraps modulo 2^TW. For example, a hit stamped near the top of the range is matched by a trigger after the counter has wrapped.
- R5: An unmatched stamp whose age (time_i minus stamp, mod 256) exceeds 120 is discarded and its slot freed. After a full store has aged out, 16 new hits are accepted with ovf_o still 0.
- R6: A hit_i in a cycle that starts with all DEPTH slots occupied is dropped, so no later trigger matches it. ovf_o becomes 1 in the next cycle and stays 1 until reset.
- R7: A matched stamp keeps its slot, whatever its age, until rd_ack_i is asserted while sel_o is 1. That acknowledge clears sel_o in the next cycle and frees every matched slot.
- R8: rd_ack_i while sel_o is 0 has no effect: stored stamps stay matchable.
- R9: A hit_i and an l1_i in the same cycle are both handled. The match uses the contents from before the write, and the new stamp can be matched by a later trigger.
- R10: When several held stamps equal the delayed time, all are matched and one acknowledge frees them all.
- R11: An acknowledge in the same cycle as a new match leaves sel_o at 1, and a later acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Pixel hit strobe |
| time_i | input | TW | Free-running crossing counter |
| l1_i | input | 1 | Level-1 trigger strobe |
| rd_ack_i | input | 1 | Readout acknowledge |
| sel_o | output | 1 | Pixel selected for level-2 readout |
| ovf_o | output | 1 | Sticky flag: a hit was lost to a full store |

## Verification
Two pairs of events can land on the same clock edge: a hit written together with a trigger comparison, and a read acknowledge together with a fresh trigger match. The bench provokes the first by raising hit_i in exactly the cycle whose delayed time equals an earlier stamp. It then requires both the immediate selection and a second selection 120 crossings later for the new stamp. The second pair is provoked with two hits one crossing apart, acknowledging the first match in the cycle the second trigger fires; sel_o must stay high and fall only on the following acknowledge.

// File: rtl/hts_pkg.sv
package hts_pkg;

  // Reduce a value to the low tw bits (tw <= 16).
  function automatic logic [15:0] hts_wrap(input logic [15:0] v, input int tw);
    return 16'(({16'd0, v}) & ((32'd1 << tw) - 32'd1));
  endfunction

  // Crossings elapsed since a stamp, modulo the counter range.
  function automatic logic [15:0] hts_age(input logic [15:0] now, input logic [15:0] stamp,
                                          input int tw);
    return hts_wrap(now - stamp, tw);
  endfunction

  // Crossing that a trigger seen now refers to.
  function automatic logic [15:0] hts_target(input logic [15:0] now, input int lat, input int tw);
    return hts_wrap(now - 16'(lat), tw);
  endfunction

endpackage

// File: rtl/hts_pick.sv
module hts_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o
);
  // Lowest free slot wins; the downward loop lets lower indices overwrite.
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) grant_o = N'(1) << i;
    end
  end
endmodule

// File: rtl/hts_slot.sv
module hts_slot
  import hts_pkg::*;
#(
  parameter int TW  = 8,
  parameter int LAT = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [TW-1:0] now_i,
  input  logic [15:0]   tgt_i,
  input  logic          l1_i,
  input  logic          take_i,
  output logic          valid_o,
  output logic          match_o
);
  logic          valid_q, mark_q;
  logic [TW-1:0] stamp_q;
  logic [15:0]   age_w;
  logic          stale_w;

  assign age_w   = hts_age(16'(now_i), 16'(stamp_q), TW);
  assign stale_w = valid_q && !mark_q && (age_w > 16'(LAT));
  assign match_o = valid_q && !mark_q && l1_i && (16'(stamp_q) == tgt_i);
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mark_q  <= 1'b0;
      stamp_q <= '0;
    end else if (wr_en_i) begin
      valid_q <= 1'b1;
      mark_q  <= 1'b0;
      stamp_q <= now_i;
    end else if (stale_w || (take_i && mark_q)) begin
      valid_q <= 1'b0;
      mark_q  <= 1'b0;
    end else if (match_o) begin
      mark_q  <= 1'b1;
    end
  end

  // R5: an aged-out entry is gone one edge later
  a_r5_stale_freed: assert property (@(posedge clk) disable iff (!rst_n)
    stale_w |=> !valid_q);
  // R7: a marked entry survives until the acknowledge takes it
  a_r7_marked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q && !take_i) |=> valid_q);
endmodule

// File: rtl/hit_time_store.sv
module hit_time_store
  import hts_pkg::*;
#(
  parameter int TW    = 8,
  parameter int LAT   = 120,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [TW-1:0] time_i,
  input  logic          l1_i,
  input  logic          rd_ack_i,
  output logic          sel_o,
  output logic          ovf_o
);
  logic [DEPTH-1:0] slot_valid, slot_match, wr_grant;
  logic [15:0]      l1_tgt;
  logic             store_full, hit_drop, hit_write, match_any, ack_take;
  logic             sel_q, ovf_q;

  assign l1_tgt     = hts_target(16'(time_i), LAT, TW);
  assign store_full = &slot_valid;
  assign hit_drop   = hit_i && store_full;
  assign hit_write  = hit_i && !store_full;
  assign match_any  = |slot_match;
  assign ack_take   = rd_ack_i && sel_q;

  hts_pick #(.N(DEPTH)) pick_i (
    .free_i (~slot_valid),
    .grant_o(wr_grant)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    hts_slot #(.TW(TW), .LAT(LAT)) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(hit_write && wr_grant[g]),
      .now_i  (time_i),
      .tgt_i  (l1_tgt),
      .l1_i   (l1_i),
      .take_i (ack_take),
      .valid_o(slot_valid[g]),
      .match_o(slot_match[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (match_any)     sel_q <= 1'b1;
      else if (ack_take) sel_q <= 1'b0;
      if (hit_drop)      ovf_q <= 1'b1;
    end
  end

  assign sel_o = sel_q;
  assign ovf_o = ovf_q;

  // R2: a match raises the selection on the next edge
  a_r2_match_selects: assert property (@(posedge clk) disable iff (!rst_n)
    match_any |=> sel_o);
  // R3: the selection only rises after a trigger
  a_r3_rise_needs_l1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> $past(l1_i));
  // R6: a lost hit raises the overflow flag
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    hit_drop |=> ovf_o);
  // R6: overflow is sticky
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  // R6: at most one slot is filled per cycle
  a_r6_one_write_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_valid) <= $past($countones(slot_valid)) + 1);
  // R7: an acknowledge without a new match drops the selection
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && rd_ack_i && !match_any) |=> !sel_o);
endmodule

// File: tb/hit_time_store_tb_top.sv
module hit_time_store_tb_top;
  localparam int TW = 8, LAT = 120, DEPTH = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          hit = 1'b0, l1 = 1'b0, ack = 1'b0;
  logic [TW-1:0] tnow = '0;
  logic          sel, ovf;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #2ns clk = ~clk;

  hit_time_store #(.TW(TW), .LAT(LAT), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .time_i(tnow),
    .l1_i(l1), .rd_ack_i(ack), .sel_o(sel), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (time_i=%0d)", req, act, exp, tnow);
    end
  endtask

  // One clock cycle with the given strobes; outputs are settled on return.
  task automatic step(input bit h, input bit l, input bit a, input bit adv);
    hit = h; l1 = l; ack = a;
    @(negedge clk);
    hit = 1'b0; l1 = 1'b0; ack = 1'b0;
    if (adv) tnow = tnow + 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  task automatic idle_to(input logic [TW-1:0] t);
    while (tnow != t) step(0, 0, 0, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 1);
  endtask

  initial begin
    logic [TW-1:0] h, x;
    do_reset();
    chk("R1 sel", sel, 1'b0);
    chk("R1 ovf", ovf, 1'b0);

    // Sweep of trigger offsets around the latency, from several hit times.
    for (int s = 0; s < 7; s++) begin
      for (int d = LAT - 6; d <= LAT + 6; d++) begin
        h = TW'(s * 41 + 10);
        idle_to(h);
        step(1, 0, 0, 1);
        idle_to(TW'(int'(h) + d));
        step(0, 1, 0, 1);
        if (int'(h) + d > 255) chk("R4 wrapped offset", sel, d == LAT);
        else if (d == LAT)     chk("R2 exact offset", sel, 1'b1);
        else                   chk("R3 off by offset", sel, 1'b0);
        if (sel) begin
          step(0, 0, 1, 1);
          chk("R7 ack clears", sel, 1'b0);
        end
        idle(130);
      end
    end

    // Aging frees slots; then a full store drops a hit.
    do_reset();
    hits(DEPTH);
    chk("R6 full no ovf yet", ovf, 1'b0);
    idle(140);
    hits(DEPTH);
    chk("R5 aged slots reused", ovf, 1'b0);
    x = tnow;
    step(1, 0, 0, 1);
    chk("R6 drop sets ovf", ovf, 1'b1);
    idle_to(TW'(int'(x) + LAT));
    step(0, 1, 0, 1);
    chk("R6 dropped hit unmatched", sel, 1'b0);
    idle(5);
    chk("R6 ovf sticky", ovf, 1'b1);
    do_reset();
    chk("R1 ovf cleared", ovf, 1'b0);
    chk("R1 sel cleared", sel, 1'b0);

    // Matched entry keeps its slot until acknowledged.
    h = tnow;
    hits(DEPTH);
    idle_to(TW'(int'(h) + LAT));
    step(0, 1, 0, 1);
    chk("R2 first of full store", sel, 1'b1);
    idle(30);
    hits(DEPTH - 1);
    chk("R7 held slot, room left", ovf, 1'b0);
    step(1, 0, 0, 1);
    chk("R7 held slot occupies", ovf, 1'b1);
    step(0, 0, 1, 1);
    chk("R7 ack clears", sel, 1'b0);

    // Acknowledge frees the held slot.
    do_reset();
    h = tnow;
    hits(DEPTH);
    idle_to(TW'(int'(h) + LAT));
    step(0, 1, 0, 1);
    chk("R2 select again", sel, 1'b1);
    idle(30);
    step(0, 0, 1, 1);
    chk("R7 ack clears", sel, 1'b0);
    hits(DEPTH);
    chk("R7 ack frees slot", ovf, 1'b0);

    // Acknowledge without selection is ignored.
    do_reset();
    h = tnow;
    step(1, 0, 0, 1);
    step(0, 0, 1, 1);
    chk("R8 stray ack", sel, 1'b0);
    idle_to(TW'(int'(h) + LAT));
    step(0, 1, 0, 1);
    chk("R8 entry survived ack", sel, 1'b1);
    step(0, 0, 1, 1);
    idle(130);

    // Hit and trigger in one cycle.
    h = tnow;
    step(1, 0, 0, 1);
    idle_to(TW'(int'(h) + LAT));
    step(1, 1, 0, 1);
    chk("R9 trigger with hit", sel, 1'b1);
    step(0, 0, 1, 1);
    chk("R9 ack", sel, 1'b0);
    idle_to(TW'(int'(h) + 2 * LAT));
    step(0, 1, 0, 1);
    chk("R9 same-cycle hit stored", sel, 1'b1);
    step(0, 0, 1, 1);
    idle(130);

    // Stalled counter: three equal stamps, one acknowledge frees all.
    h = tnow;
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    idle_to(TW'(int'(h) + LAT));
    step(0, 1, 0, 0);
    chk("R10 equal stamps select", sel, 1'b1);
    step(0, 0, 1, 0);
    chk("R10 ack", sel, 1'b0);
    step(0, 1, 0, 0);
    chk("R10 all equal stamps freed", sel, 1'b0);
    step(0, 0, 0, 1);
    idle(130);

    // Acknowledge meets a new match.
    h = tnow;
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    idle_to(TW'(int'(h) + LAT));
    step(0, 1, 0, 1);
    chk("R11 first match", sel, 1'b1);
    step(0, 1, 1, 1);
    chk("R11 ack with new match", sel, 1'b1);
    step(0, 0, 1, 1);
    chk("R11 final ack", sel, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule